// File: doc/BRIEF.md
# Lockable L2 Tag Controller with Parity Recovery

This block is the tag side of a set-associative second-level cache. It sees bus transfers that can carry a lock attribute. A burst read (plain, with intent to modify, or claim) that carries the attribute pins the addressed line. A copy-back write burst that carries the attribute does the same. If the line is absent, the controller first takes a free way for it. Lines the controller already holds answer lookups with a hit. A kill transfer drops a line and clears its lock. Data storage and memory timing belong to other blocks.

Each tag entry keeps one even-parity bit over its tag. The parity is checked again on every lookup, and a corrupt entry never hits. When an allocation finds a corrupt entry in its set, the controller raises a sticky parity error and leaves the set untouched. A kill aimed at the corrupt line sees only a miss, so it cannot repair the entry. The only recovery is the wipe sequence. It clears every set, one set per clock, holds the request port not-ready while it runs, and drops the error flag when it ends.

The controller has two enumerated states. IDLE accepts requests and does one lookup per clock. WIPE walks the sets. Three transitions exist. IDLE goes to WIPE when `wipe_req` is seen. WIPE stays in WIPE while the set counter is below the last set. WIPE goes back to IDLE after the last set has been cleared.

Top module: `l2lk_tag_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, and `wipe_busy`, `tag_perr` and `rsp_valid` are 0. Every address misses.
- R2: A request accepted on a clock edge (`req_valid` and `req_ready` both high) gives `rsp_valid` high in the next cycle, and only then. `rsp_hit` is 1 exactly when a valid entry with good parity in the addressed set holds the request's tag. `rsp_locked` tells whether that line is locked once the operation is done.
- R3: A request with `req_lock`=1 and `req_xfer` of 0 (read), 1 (read with intent to modify) or 2 (read claim) that misses allocates the line and locks it. Later lookups of that address hit with `rsp_locked`=1.
- R4: A lockable request that hits locks the existing line, reports hit and locked, and allocates nothing: the other lines of the set keep hitting.
- R5: A request with `req_xfer`=3 (write burst), `req_lock`=1 and `req_wt`=0 allocates and locks like R3. With `req_wt`=1 it allocates nothing.
- R6: A request with `req_lock`=0 never allocates. Codes 5 to 7 only look up. On a miss without lock, `rsp_locked` is 0.
- R7: An allocation takes the lowest-numbered invalid way and never replaces a locked way. If every way of the set is locked, the request ends with `rsp_locked`=0 and the set is unchanged.
- R8: With `req_upset`=1 during an allocation, the entry is stored with a corrupted tag. Lookups of that address then miss. A later lockable miss in that set sets `tag_perr` and allocates nothing.
- R9: `req_xfer`=4 (kill) on a hit clears the line's valid and lock bits, and the response shows `rsp_locked`=0. A kill aimed at a corrupt entry is a miss and leaves the corrupt entry in place.
- R10: `tag_perr` stays set until a wipe ends. While it is set, no allocation takes place.
- R11: `wipe_req` seen in IDLE raises `wipe_busy` for exactly SETS cycles, and `req_ready` is 0 during that time. Afterwards every line is invalid and unlocked, and `tag_perr` is 0.
- R12: While `wipe_req` is high, `req_ready` is 0. A request offered in the same cycle is not accepted and gets no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_addr | input | ADDR_W | Byte address of the request |
| req_xfer | input | 3 | Transfer code: 0 read, 1 read-own, 2 read-claim, 3 write burst, 4 kill, 5-7 lookup only |
| req_lock | input | 1 | Lock attribute |
| req_wt | input | 1 | Write-through attribute |
| req_upset | input | 1 | Stores a corrupted tag on this request's allocation (array upset model) |
| wipe_req | input | 1 | Starts the wipe of all sets |
| rsp_valid | output | 1 | Response for the request accepted one cycle earlier |
| rsp_hit | output | 1 | Lookup hit |
| rsp_locked | output | 1 | Addressed line locked after the operation |
| tag_perr | output | 1 | Sticky tag parity error |
| wipe_busy | output | 1 | Wipe in progress |

## Verification
On every cycle the assertions check the handshake and the sequencing. They check that a response follows exactly the accepted requests, that the port is not-ready during a wipe or a wipe request, that a wipe lasts exactly SETS cycles and leaves the error flag clear, and that the error flag holds outside a wipe. They also check that kills and unlocked misses never report a locked line. Only the bench scenarios can show the effects that depend on stored state: allocation into the right set, the full-set refusal, a corrupt entry that stays invisible to lookups and kills, and a wipe that really empties every line.

// File: rtl/l2lk_pkg.sv
package l2lk_pkg;
    localparam logic [2:0] XFER_RD       = 3'd0;
    localparam logic [2:0] XFER_RD_OWN   = 3'd1;
    localparam logic [2:0] XFER_RD_CLAIM = 3'd2;
    localparam logic [2:0] XFER_WR_BURST = 3'd3;
    localparam logic [2:0] XFER_KILL     = 3'd4;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WIPE = 1'b1
    } ctrl_state_t;
endpackage

// File: rtl/l2lk_way_cmp.sv
module l2lk_way_cmp #(
    parameter int TAG_W = 23
) (
    input  logic             vld,
    input  logic [TAG_W-1:0] stored_tag,
    input  logic             stored_par,
    input  logic [TAG_W-1:0] probe_tag,
    output logic             match,
    output logic             bad
);
    // Even parity: stored bit equals the XOR of the tag bits.
    always_comb begin
        bad   = vld && ((^stored_tag) != stored_par);
        match = vld && !bad && (stored_tag == probe_tag);
    end
endmodule

// File: rtl/l2lk_victim.sv
module l2lk_victim #(
    parameter int WAYS  = 4,
    parameter int WAY_W = 2
) (
    input  logic [WAYS-1:0]  vld,
    input  logic [WAYS-1:0]  lck,
    output logic             found,
    output logic [WAY_W-1:0] way
);
    always_comb begin
        found = 1'b0;
        way   = '0;
        // Lowest unlocked valid way, overridden by the lowest invalid way.
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (vld[w] && !lck[w]) begin
                found = 1'b1;
                way   = WAY_W'(w);
            end
        end
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!vld[w]) begin
                found = 1'b1;
                way   = WAY_W'(w);
            end
        end
    end
endmodule

// File: rtl/l2lk_tag_ctrl.sv
module l2lk_tag_ctrl
    import l2lk_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 5,
    parameter int SETS   = 16,
    parameter int WAYS   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [2:0]        req_xfer,
    input  logic              req_lock,
    input  logic              req_wt,
    input  logic              req_upset,
    input  logic              wipe_req,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_locked,
    output logic              tag_perr,
    output logic              wipe_busy
);
    localparam int IDX_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
    localparam logic [IDX_W-1:0] LAST_SET = IDX_W'(SETS - 1);

    ctrl_state_t state_q, state_d;

    logic [TAG_W-1:0] tag_q [SETS][WAYS];
    logic [WAYS-1:0]  par_q [SETS];
    logic [WAYS-1:0]  vld_q [SETS];
    logic [WAYS-1:0]  lck_q [SETS];
    logic [IDX_W-1:0] wipe_idx_q;
    logic             perr_q, rsp_valid_q, rsp_hit_q, rsp_locked_q;

    logic [IDX_W-1:0] set_i;
    logic [TAG_W-1:0] tag_i;
    logic [WAYS-1:0]  hit_vec, bad_vec;
    logic [WAY_W-1:0] hit_way, vic_way;
    logic             hit_any, bad_any, vic_ok, accept;
    logic             read_kind, lockable, kill, do_alloc, perr_set, lock_after;

    assign set_i = req_addr[OFF_W +: IDX_W];
    assign tag_i = req_addr[ADDR_W-1 -: TAG_W];

    for (genvar g = 0; g < WAYS; g++) begin : g_way
        l2lk_way_cmp #(.TAG_W(TAG_W)) u_cmp (
            .vld        (vld_q[set_i][g]),
            .stored_tag (tag_q[set_i][g]),
            .stored_par (par_q[set_i][g]),
            .probe_tag  (tag_i),
            .match      (hit_vec[g]),
            .bad        (bad_vec[g])
        );
    end

    l2lk_victim #(.WAYS(WAYS), .WAY_W(WAY_W)) u_vic (
        .vld   (vld_q[set_i]),
        .lck   (lck_q[set_i]),
        .found (vic_ok),
        .way   (vic_way)
    );

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) hit_way = WAY_W'(w);
        end
        hit_any   = |hit_vec;
        bad_any   = |bad_vec;
        accept    = req_valid && req_ready;
        kill      = (req_xfer == XFER_KILL);
        read_kind = (req_xfer == XFER_RD) || (req_xfer == XFER_RD_OWN) ||
                    (req_xfer == XFER_RD_CLAIM);
        lockable  = req_lock && (read_kind || ((req_xfer == XFER_WR_BURST) && !req_wt));
        do_alloc  = lockable && !hit_any && !bad_any && !perr_q && vic_ok;
        perr_set  = lockable && !hit_any && bad_any;
        if (kill)          lock_after = 1'b0;
        else if (lockable) lock_after = hit_any || do_alloc;
        else               lock_after = hit_any && lck_q[set_i][hit_way];
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (wipe_req) state_d = ST_WIPE;
            ST_WIPE: if (wipe_idx_q == LAST_SET) state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        req_ready = 1'b0;
        wipe_busy = 1'b0;
        unique case (state_q)
            ST_IDLE: req_ready = !wipe_req;
            ST_WIPE: wipe_busy = 1'b1;
        endcase
        rsp_valid  = rsp_valid_q;
        rsp_hit    = rsp_hit_q;
        rsp_locked = rsp_locked_q;
        tag_perr   = perr_q;
    end

    // Tag and parity storage (no reset; valid bits guard them)
    always_ff @(posedge clk) begin
        if (accept && do_alloc) begin
            tag_q[set_i][vic_way] <= tag_i ^ {{(TAG_W-1){1'b0}}, req_upset};
            par_q[set_i][vic_way] <= ^tag_i;
        end
    end

    // Line state, error flag, wipe walk and response registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s] <= '0;
                lck_q[s] <= '0;
            end
            wipe_idx_q   <= '0;
            perr_q       <= 1'b0;
            rsp_valid_q  <= 1'b0;
            rsp_hit_q    <= 1'b0;
            rsp_locked_q <= 1'b0;
        end else begin
            rsp_valid_q <= accept;
            if (accept) begin
                rsp_hit_q    <= hit_any;
                rsp_locked_q <= lock_after;
                if (kill && hit_any) begin
                    vld_q[set_i][hit_way] <= 1'b0;
                    lck_q[set_i][hit_way] <= 1'b0;
                end else if (lockable && hit_any) begin
                    lck_q[set_i][hit_way] <= 1'b1;
                end else if (do_alloc) begin
                    vld_q[set_i][vic_way] <= 1'b1;
                    lck_q[set_i][vic_way] <= 1'b1;
                end
                if (perr_set) perr_q <= 1'b1;
            end
            if (state_q == ST_WIPE) begin
                vld_q[wipe_idx_q] <= '0;
                lck_q[wipe_idx_q] <= '0;
                if (wipe_idx_q == LAST_SET) begin
                    wipe_idx_q <= '0;
                    perr_q     <= 1'b0;
                end else begin
                    wipe_idx_q <= wipe_idx_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/l2lk_tag_ctrl_chk.sv
module l2lk_tag_ctrl_chk #(
    parameter int SETS = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic [2:0] req_xfer,
    input logic       req_lock,
    input logic       wipe_req,
    input logic       rsp_valid,
    input logic       rsp_hit,
    input logic       rsp_locked,
    input logic       tag_perr,
    input logic       wipe_busy
);
    int busy_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         busy_run <= 0;
        else if (wipe_busy) busy_run <= busy_run + 1;
        else                busy_run <= 0;
    end

    p_rsp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);
    p_rsp_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready) |=> !rsp_valid);
    p_nolock_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !$past(req_lock) && !rsp_hit) |-> !rsp_locked);
    p_kill_unlocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && ($past(req_xfer) == 3'd4)) |-> !rsp_locked);
    p_perr_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_perr && !wipe_busy) |=> tag_perr);
    p_busy_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wipe_busy |-> !req_ready);
    p_busy_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wipe_busy |-> (busy_run < SETS));
    p_busy_len_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wipe_busy) |-> (busy_run == SETS));
    p_perr_cleared_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wipe_busy) |-> !tag_perr);
    p_wipe_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        wipe_req |-> !req_ready);
endmodule

bind l2lk_tag_ctrl l2lk_tag_ctrl_chk #(.SETS(SETS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_xfer   (req_xfer),
    .req_lock   (req_lock),
    .wipe_req   (wipe_req),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_locked (rsp_locked),
    .tag_perr   (tag_perr),
    .wipe_busy  (wipe_busy)
);

// File: tb/l2lk_tag_ctrl_test.sv
module l2lk_tag_ctrl_test;
    localparam int ADDR_W = 32;
    localparam int OFF_W  = 5;
    localparam int SETS   = 16;
    localparam int WAYS   = 4;
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_lock = 1'b0, req_wt = 1'b0, req_upset = 1'b0, wipe_req = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [2:0] req_xfer = '0;
    logic req_ready, rsp_valid, rsp_hit, rsp_locked, tag_perr, wipe_busy;

    always #2 clk = ~clk;

    l2lk_tag_ctrl #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .SETS(SETS), .WAYS(WAYS)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_xfer(req_xfer), .req_lock(req_lock), .req_wt(req_wt),
        .req_upset(req_upset), .wipe_req(wipe_req), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_locked(rsp_locked), .tag_perr(tag_perr),
        .wipe_busy(wipe_busy)
    );

    int nchk = 0, nerr = 0;
    bit done = 1'b0;

    // Shadow of the line state, built from the requirements
    bit               mv [SETS][WAYS];
    bit               ml [SETS][WAYS];
    bit               mf [SETS][WAYS];
    logic [TAG_W-1:0] mt [SETS][WAYS];
    bit               mperr;

    task automatic check(string rq, string what, int act, int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] mk(int t, int s);
        return {TAG_W'(t), IDX_W'(s), OFF_W'(0)};
    endfunction

    task automatic model_clear();
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                mv[s][w] = 0; ml[s][w] = 0; mf[s][w] = 0; mt[s][w] = '0;
            end
        mperr = 0;
    endtask

    task automatic model_op(int kind, int t, int s, bit lk, bit wt, bit inj,
                            output bit eh, output bit el);
        int hw = -1, vw = -1;
        bit anyf = 0, lockable;
        for (int w = 0; w < WAYS; w++) begin
            if (mv[s][w] && mf[s][w]) anyf = 1;
            if (mv[s][w] && !mf[s][w] && mt[s][w] == TAG_W'(t)) hw = w;
        end
        for (int w = WAYS - 1; w >= 0; w--) if (!mv[s][w]) vw = w;
        lockable = lk && (kind <= 2 || (kind == 3 && !wt));
        eh = (hw >= 0);
        el = 0;
        if (kind == 4) begin
            if (eh) begin mv[s][hw] = 0; ml[s][hw] = 0; end
        end else if (lockable) begin
            if (eh) begin ml[s][hw] = 1; el = 1; end
            else if (anyf) mperr = 1;
            else if (!mperr && vw >= 0) begin
                mv[s][vw] = 1; ml[s][vw] = 1; mf[s][vw] = inj; mt[s][vw] = TAG_W'(t);
                el = 1;
            end
        end else begin
            el = eh && ml[s][hw];
        end
    endtask

    task automatic do_op(string rq, int kind, int t, int s, bit lk, bit wt, bit inj);
        bit eh, el;
        @(negedge clk);
        check(rq, "ready before request", int'(req_ready), 1);
        req_valid = 1; req_xfer = 3'(kind); req_addr = mk(t, s);
        req_lock = lk; req_wt = wt; req_upset = inj;
        model_op(kind, t, s, lk, wt, inj, eh, el);
        @(negedge clk);
        req_valid = 0; req_upset = 0;
        check(rq, "rsp_valid", int'(rsp_valid), 1);
        check(rq, "rsp_hit", int'(rsp_hit), int'(eh));
        check(rq, "rsp_locked", int'(rsp_locked), int'(el));
        check(rq, "tag_perr", int'(tag_perr), int'(mperr));
    endtask

    task automatic do_wipe();
        int n = 0;
        @(negedge clk);
        wipe_req = 1; req_valid = 1; req_xfer = 3'd0; req_lock = 1; req_addr = mk(9, 3);
        #1 check("R12", "ready while wipe_req", int'(req_ready), 0);
        @(negedge clk);
        wipe_req = 0; req_valid = 0;
        check("R12", "no response to refused request", int'(rsp_valid), 0);
        while (wipe_busy && n < 100) begin
            check("R11", "ready during wipe", int'(req_ready), 0);
            n++;
            @(negedge clk);
        end
        check("R11", "wipe length", n, SETS);
        check("R11", "perr after wipe", int'(tag_perr), 0);
        model_clear();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL R11 watchdog expired: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        model_clear();
        repeat (3) @(negedge clk);
        check("R1", "ready in reset", int'(req_ready), 1);
        rst_n = 1;
        @(negedge clk);
        check("R1", "ready", int'(req_ready), 1);
        check("R1", "wipe_busy", int'(wipe_busy), 0);
        check("R1", "tag_perr", int'(tag_perr), 0);
        check("R1", "rsp_valid", int'(rsp_valid), 0);
        do_op("R1", 0, 1, 1, 0, 0, 0);            // miss after reset
        do_op("R6", 0, 1, 1, 0, 0, 0);            // no-lock read does not allocate
        do_op("R6", 6, 1, 1, 1, 0, 0);            // lookup-only code with lock
        do_op("R6", 1, 1, 1, 0, 0, 0);            // still a miss
        do_op("R3", 0, 1, 1, 1, 0, 0);            // A allocates
        do_op("R2", 0, 1, 1, 0, 0, 0);            // A hits locked
        do_op("R3", 1, 2, 1, 1, 0, 0);            // B
        do_op("R3", 2, 3, 1, 1, 0, 0);            // C
        do_op("R5", 3, 4, 1, 1, 1, 0);            // write-through: no allocation
        do_op("R5", 0, 4, 1, 0, 0, 0);            // D still misses
        do_op("R5", 3, 4, 1, 1, 0, 0);            // D allocates
        do_op("R7", 0, 5, 1, 1, 0, 0);            // full set: refused
        do_op("R7", 5, 5, 1, 0, 0, 0);            // E absent
        do_op("R4", 2, 1, 1, 1, 0, 0);            // lock on hit
        do_op("R4", 0, 2, 1, 0, 0, 0);
        do_op("R4", 0, 4, 1, 0, 0, 0);
        do_op("R9", 4, 2, 1, 0, 0, 0);            // kill B
        do_op("R9", 0, 2, 1, 0, 0, 0);            // B gone
        do_op("R7", 0, 5, 1, 1, 0, 0);            // E takes the freed way
        do_op("R7", 0, 1, 1, 0, 0, 0);
        do_op("R7", 0, 3, 1, 0, 0, 0);
        do_op("R8", 0, 7, 5, 1, 0, 1);            // corrupt entry stored
        do_op("R8", 0, 7, 5, 0, 0, 0);            // corrupt entry misses
        do_op("R9", 4, 7, 5, 0, 0, 0);            // kill sees a miss
        do_op("R8", 1, 8, 5, 1, 0, 0);            // allocation finds fault
        check("R8", "perr raised", int'(tag_perr), 1);
        do_op("R10", 0, 6, 2, 1, 0, 0);           // no allocation while flagged
        do_op("R10", 0, 6, 2, 0, 0, 0);
        do_op("R10", 0, 1, 1, 1, 0, 0);           // hit still locks
        do_wipe();
        do_op("R11", 0, 1, 1, 0, 0, 0);           // wiped
        do_op("R11", 0, 7, 5, 1, 0, 0);           // set 5 usable again
        for (int i = 0; i < 500; i++) begin
            int k = int'($urandom % 6);
            bit lk = ($urandom % 10) < 6;
            if (($urandom % 90) == 0) do_wipe();
            else do_op("R2", k, int'($urandom % 6), int'($urandom % 3), lk,
                       bit'($urandom % 2), ($urandom % 40) == 0);
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule